// File: doc/BRIEF.md
# System Management Interrupt Aggregator

The block merges a set of on-chip peripheral interrupt lines and a bank of general-purpose pin events into one system management interrupt. Each source contributes its status bit ANDed with an enable bit, and the results are ORed together. Peripheral sources are reported live and are not latched. The exception is the infrared source, which is held until software reads its status register. Pin events are latched by an edge detector and are cleared only when software writes 1 to the bit. The edge can be rising, falling or both, chosen per pin.

The combined request drives a registered two-state controller. Its states are `SMI_IDLE` and `SMI_ACTIVE`. It moves from `SMI_IDLE` to `SMI_ACTIVE` on the first clock edge at which the combined request is high. It moves from `SMI_ACTIVE` back to `SMI_IDLE` on the first edge at which the request is low.

From the `SMI_ACTIVE` state, two routing bits send the interrupt to the group output pin and to a slot-2 request flag for a serial IRQ encoder. The pin has a programmable active level and a programmable drive type, open-drain or push-pull. Software uses a byte-wide register port. Reads return data combinationally from the address.

Top module: `smi_aggregator`

## Requirements
- R1: The interrupt is the OR over all sources of status AND enable. The `SMI_ACTIVE` state, and the outputs that depend on it, follow that OR one clock edge later.
- R2: Peripheral sources 0..7 read at address 0, and sources 9..13 read at address 1 bits 5:1. They mirror the live input level. Writing these bits has no effect.
- R3: The infrared source (source 8, address 1 bit 0) is latched when its input is high. A read strobe on address 1 clears it, unless the input is high in that same cycle.
- R4: Pin n has its status at address 2+n/8, bit n%8. A pin status bit stays set until a write of 1 to that bit. Writing 0 leaves it unchanged.
- R5: With the polarity bit clear (addresses 16+n/8), a rising pin edge sets the status bit. With the polarity bit set, a falling edge sets it.
- R6: With the both-edges bit set (addresses 24+n/8), either transition sets the status bit. The polarity bit is then ignored.
- R7: Enable register 2 (address 9) bit 7 routes the interrupt to the pin. Bit 6 routes it to `serirq_slot2_req`. Bits 5:0 enable sources 8..13. Enables for sources 0..7 are at address 8, and pin enables are at addresses 10+n/8.
- R8: Address 31 bit 0 selects active-high, and bit 1 selects push-pull. In push-pull mode, `smi_oe` is always 1. In open-drain mode, `smi_oe` is 1 only while the pin is asserted, and `smi_o` always carries the active level.
- R9: After reset, every register reads 0 and the output is active-low and open-drain with `smi_oe` at 0.
- R10: When a write-1-to-clear and a new edge land on the same bit in the same cycle, the bit stays set.
- R11: Pin inputs pass through two synchronizer flops. A pin change shows up in its status bit after the third rising clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| dev_irq | input | 14 | Peripheral interrupt levels |
| pin_in | input | 8*NUM_PIN_BYTES | Asynchronous general-purpose pin inputs |
| smi_o | output | 1 | Group pin data |
| smi_oe | output | 1 | Group pin output enable |
| serirq_slot2_req | output | 1 | Serial IRQ slot 2 request |

## Verification
Two pin-side events can meet in one cycle: a software write-1-to-clear, and the edge-detector pulse for the same bit. The bench produces this by changing a pin, waiting exactly two clock edges, and then placing the clearing write on the third edge, where the synchronized edge lands. The bit must read back as set afterwards. A second race, between a read strobe on status register 2 and the infrared latch, is handled by driving the read only after the source has dropped and confirming that the bit then reads 0.

// File: rtl/smi_pkg.sv
package smi_pkg;
    localparam int unsigned DEV_SRC = 14;
    localparam int unsigned IR_IDX  = 8;
    localparam int unsigned ADDR_W  = 5;

    localparam int unsigned A_STS_BASE  = 0;
    localparam int unsigned A_EN_BASE   = 8;
    localparam int unsigned A_POL_BASE  = 16;
    localparam int unsigned A_BOTH_BASE = 24;
    localparam int unsigned A_OUTCTL    = 31;

    typedef enum logic [0:0] {
        SMI_IDLE   = 1'b0,
        SMI_ACTIVE = 1'b1
    } smi_state_e;

    typedef struct packed {
        logic push_pull;
        logic act_high;
    } out_cfg_t;
endpackage

// File: rtl/smi_pin_event.sv
module smi_pin_event (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic pol_inv,
    input  logic both_edge,
    input  logic clr_w1c,
    output logic sts_o
);
    logic sync1_q, sync2_q, prev_q;
    logic edge_hit;
    logic sts_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= pin_async;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    always_comb begin
        if (both_edge)
            edge_hit = sync2_q ^ prev_q;
        else if (pol_inv)
            edge_hit = prev_q & ~sync2_q;
        else
            edge_hit = sync2_q & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sts_q <= 1'b0;
        else if (edge_hit)
            sts_q <= 1'b1;
        else if (clr_w1c)
            sts_q <= 1'b0;
    end

    assign sts_o = sts_q;

    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> sts_q); // R10
    AST_PIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sts_q && !clr_w1c |=> sts_q); // R4
endmodule

// File: rtl/smi_dev_status.sv
module smi_dev_status
    import smi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DEV_SRC-1:0] dev_irq,
    input  logic               rd_sts2,
    output logic [DEV_SRC-1:0] dev_sts
);
    logic ir_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ir_q <= 1'b0;
        else if (dev_irq[IR_IDX])
            ir_q <= 1'b1;
        else if (rd_sts2)
            ir_q <= 1'b0;
    end

    always_comb begin
        dev_sts         = dev_irq;
        dev_sts[IR_IDX] = ir_q;
    end

    AST_IR_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sts2 && !dev_irq[IR_IDX] |=> !ir_q); // R3
    AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ir_q && !rd_sts2 |=> ir_q); // R3
endmodule

// File: rtl/smi_regs.sv
module smi_regs
    import smi_pkg::*;
#(
    parameter int unsigned NUM_PIN_BYTES = 5,
    localparam int unsigned NUM_PINS = NUM_PIN_BYTES * 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    input  logic [DEV_SRC-1:0]  dev_sts,
    input  logic [NUM_PINS-1:0] pin_sts,
    output logic [DEV_SRC-1:0]  dev_en,
    output logic [NUM_PINS-1:0] pin_en,
    output logic [NUM_PINS-1:0] pin_pol,
    output logic [NUM_PINS-1:0] pin_both,
    output logic [NUM_PINS-1:0] pin_clr,
    output logic                route_pin,
    output logic                route_ser,
    output out_cfg_t            out_cfg,
    output logic                rd_sts2
);
    localparam logic [ADDR_W-1:0] A_STS1 = ADDR_W'(A_STS_BASE);
    localparam logic [ADDR_W-1:0] A_STS2 = ADDR_W'(A_STS_BASE + 1);
    localparam logic [ADDR_W-1:0] A_EN1  = ADDR_W'(A_EN_BASE);
    localparam logic [ADDR_W-1:0] A_EN2  = ADDR_W'(A_EN_BASE + 1);
    localparam logic [ADDR_W-1:0] A_OCTL = ADDR_W'(A_OUTCTL);

    logic [7:0] en1_q, en2_q;
    logic [1:0] octl_q;
    logic [7:0] pen_q  [NUM_PIN_BYTES];
    logic [7:0] pol_q  [NUM_PIN_BYTES];
    logic [7:0] both_q [NUM_PIN_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en1_q  <= 8'h00;
            en2_q  <= 8'h00;
            octl_q <= 2'b00;
        end else if (wr_en) begin
            if (addr == A_EN1)  en1_q  <= wdata;
            if (addr == A_EN2)  en2_q  <= wdata;
            if (addr == A_OCTL) octl_q <= wdata[1:0];
        end
    end

    for (genvar b = 0; b < NUM_PIN_BYTES; b++) begin : g_byte
        localparam logic [ADDR_W-1:0] A_S = ADDR_W'(A_STS_BASE + 2 + b);
        localparam logic [ADDR_W-1:0] A_E = ADDR_W'(A_EN_BASE + 2 + b);
        localparam logic [ADDR_W-1:0] A_P = ADDR_W'(A_POL_BASE + b);
        localparam logic [ADDR_W-1:0] A_B = ADDR_W'(A_BOTH_BASE + b);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pen_q[b]  <= 8'h00;
                pol_q[b]  <= 8'h00;
                both_q[b] <= 8'h00;
            end else if (wr_en) begin
                if (addr == A_E) pen_q[b]  <= wdata;
                if (addr == A_P) pol_q[b]  <= wdata;
                if (addr == A_B) both_q[b] <= wdata;
            end
        end

        assign pin_en[b*8 +: 8]   = pen_q[b];
        assign pin_pol[b*8 +: 8]  = pol_q[b];
        assign pin_both[b*8 +: 8] = both_q[b];
        assign pin_clr[b*8 +: 8]  = (wr_en && addr == A_S) ? wdata : 8'h00;
    end

    assign dev_en    = {en2_q[5:0], en1_q};
    assign route_pin = en2_q[7];
    assign route_ser = en2_q[6];
    assign out_cfg   = '{push_pull: octl_q[1], act_high: octl_q[0]};
    assign rd_sts2   = rd_en && (addr == A_STS2);

    always_comb begin
        rdata = 8'h00;
        if (addr == A_STS1) rdata = dev_sts[7:0];
        if (addr == A_STS2) rdata = {2'b00, dev_sts[DEV_SRC-1:8]};
        if (addr == A_EN1)  rdata = en1_q;
        if (addr == A_EN2)  rdata = en2_q;
        if (addr == A_OCTL) rdata = {6'b0, octl_q};
        for (int b = 0; b < NUM_PIN_BYTES; b++) begin
            if (addr == ADDR_W'(A_STS_BASE + 2 + b))  rdata = pin_sts[b*8 +: 8];
            if (addr == ADDR_W'(A_EN_BASE + 2 + b))   rdata = pen_q[b];
            if (addr == ADDR_W'(A_POL_BASE + b))      rdata = pol_q[b];
            if (addr == ADDR_W'(A_BOTH_BASE + b))     rdata = both_q[b];
        end
    end

    AST_STS1_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        addr == A_STS1 |-> rdata == dev_sts[7:0]); // R2
endmodule

// File: rtl/smi_out_fsm.sv
module smi_out_fsm
    import smi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     group_req,
    input  logic     route_pin,
    input  logic     route_ser,
    input  out_cfg_t cfg,
    output logic     smi_o,
    output logic     smi_oe,
    output logic     serirq_req
);
    smi_state_e state_q, state_d;
    logic asserted;
    logic pin_act;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SMI_IDLE:   if (group_req)  state_d = SMI_ACTIVE;
            SMI_ACTIVE: if (!group_req) state_d = SMI_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SMI_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        asserted = 1'b0;
        unique case (state_q)
            SMI_IDLE:   asserted = 1'b0;
            SMI_ACTIVE: asserted = 1'b1;
        endcase
        pin_act    = asserted & route_pin;
        serirq_req = asserted & route_ser;
        if (cfg.push_pull) begin
            smi_oe = 1'b1;
            smi_o  = pin_act ? cfg.act_high : ~cfg.act_high;
        end else begin
            smi_oe = pin_act;
            smi_o  = cfg.act_high;
        end
    end

    AST_OD_NO_INACTIVE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.push_pull && smi_oe |-> smi_o == cfg.act_high); // R8
    AST_SER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(group_req) && route_ser |-> serirq_req); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(group_req) |-> !serirq_req); // R1
endmodule

// File: rtl/smi_aggregator.sv
module smi_aggregator
    import smi_pkg::*;
#(
    parameter int unsigned NUM_PIN_BYTES = 5,
    localparam int unsigned NUM_PINS = NUM_PIN_BYTES * 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [4:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic [13:0]         dev_irq,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic                smi_o,
    output logic                smi_oe,
    output logic                serirq_slot2_req
);
    logic [DEV_SRC-1:0]  dev_sts, dev_en;
    logic [NUM_PINS-1:0] pin_sts, pin_en, pin_pol, pin_both, pin_clr;
    logic                route_pin, route_ser, rd_sts2, group_req;
    out_cfg_t            out_cfg;

    smi_dev_status u_dev (
        .clk     (clk),
        .rst_n   (rst_n),
        .dev_irq (dev_irq),
        .rd_sts2 (rd_sts2),
        .dev_sts (dev_sts)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        smi_pin_event u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_async (pin_in[p]),
            .pol_inv   (pin_pol[p]),
            .both_edge (pin_both[p]),
            .clr_w1c   (pin_clr[p]),
            .sts_o     (pin_sts[p])
        );
    end

    smi_regs #(.NUM_PIN_BYTES(NUM_PIN_BYTES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .rd_en     (reg_rd),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .dev_sts   (dev_sts),
        .pin_sts   (pin_sts),
        .dev_en    (dev_en),
        .pin_en    (pin_en),
        .pin_pol   (pin_pol),
        .pin_both  (pin_both),
        .pin_clr   (pin_clr),
        .route_pin (route_pin),
        .route_ser (route_ser),
        .out_cfg   (out_cfg),
        .rd_sts2   (rd_sts2)
    );

    assign group_req = (|(dev_sts & dev_en)) | (|(pin_sts & pin_en));

    smi_out_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .group_req  (group_req),
        .route_pin  (route_pin),
        .route_ser  (route_ser),
        .cfg        (out_cfg),
        .smi_o      (smi_o),
        .smi_oe     (smi_oe),
        .serirq_req (serirq_slot2_req)
    );

    AST_DEV_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == 5'd0 |-> reg_rdata == dev_irq[7:0]); // R2
endmodule

// File: tb/smi_aggregator_tb.sv
module smi_aggregator_tb;
    localparam int NB = 5;
    localparam int NP = NB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0, reg_rdata;
    logic [13:0]   dev_irq = '0;
    logic [NP-1:0] pin_in = '0;
    logic          smi_o, smi_oe, serirq_slot2_req;
    int            n_chk = 0, n_err = 0;

    always #2 clk = ~clk;

    smi_aggregator #(.NUM_PIN_BYTES(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dev_irq(dev_irq), .pin_in(pin_in), .smi_o(smi_o), .smi_oe(smi_oe),
        .serirq_slot2_req(serirq_slot2_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R9 oe after reset", {7'b0, smi_oe}, 8'h00);
        chk("R9 o after reset", {7'b0, smi_o}, 8'h00);
        peek(5'd9, d);  chk("R9 en2 reset", d, 8'h00);
        peek(5'd2, d);  chk("R9 sts3 reset", d, 8'h00);
        peek(5'd31, d); chk("R9 outctl reset", d, 8'h00);
    endtask

    task automatic t_dev();
        logic [7:0] d;
        dev_irq[7:0] = 8'h5A;
        peek(5'd0, d); chk("R2 live level", d, 8'h5A);
        wr(5'd0, 8'hFF);
        peek(5'd0, d); chk("R2 write ignored", d, 8'h5A);
        dev_irq[7:0] = 8'h00;
        peek(5'd0, d); chk("R2 clears at source", d, 8'h00);
        wr(5'd8, 8'h02);
        wr(5'd9, 8'h80);
        dev_irq[1] = 1'b1;
        idle(2);
        chk("R1 pin asserted oe", {7'b0, smi_oe}, 8'h01);
        chk("R1 pin asserted level", {7'b0, smi_o}, 8'h00);
        dev_irq[1] = 1'b0;
        idle(2);
        chk("R1 pin released", {7'b0, smi_oe}, 8'h00);
        wr(5'd8, 8'h00);
        wr(5'd9, 8'h00);
    endtask

    task automatic t_ir();
        logic [7:0] d;
        @(negedge clk); dev_irq[8] = 1'b1;
        @(negedge clk); dev_irq[8] = 1'b0;
        peek(5'd1, d); chk("R3 ir latched", d, 8'h01);
        peek(5'd1, d); chk("R3 ir held without read", d, 8'h01);
        rd(5'd1, d);   chk("R3 read returns set", d, 8'h01);
        peek(5'd1, d); chk("R3 read clears", d, 8'h00);
        dev_irq[9] = 1'b1;
        peek(5'd1, d); chk("R2 sts2 live bit", d, 8'h02);
        dev_irq[9] = 1'b0;
    endtask

    task automatic t_latency();
        logic [7:0] d;
        @(negedge clk); pin_in[0] = 1'b1;
        @(posedge clk); @(posedge clk); #1 d = reg_rdata;
        reg_addr = 5'd2; #0.5 d = reg_rdata;
        chk("R11 not set after two edges", d, 8'h00);
        @(posedge clk); #1 d = reg_rdata;
        chk("R11 set after third edge", d, 8'h01);
        wr(5'd2, 8'h01);
        peek(5'd2, d); chk("R4 w1c clears, pin still high", d, 8'h00);
        idle(3);
        peek(5'd2, d); chk("R4 held high pin does not reset", d, 8'h00);
        pin_in[0] = 1'b0;
        idle(5);
        peek(5'd2, d); chk("R5 falling ignored by default", d, 8'h00);
    endtask

    task automatic t_pol();
        logic [7:0] d;
        wr(5'd16, 8'h02);
        @(negedge clk); pin_in[1] = 1'b1;
        idle(5);
        peek(5'd2, d); chk("R5 rising ignored when inverted", d, 8'h00);
        pin_in[1] = 1'b0;
        idle(5);
        peek(5'd2, d); chk("R5 falling sets when inverted", d, 8'h02);
        wr(5'd2, 8'h02);
        wr(5'd16, 8'h00);
    endtask

    task automatic t_both();
        logic [7:0] d;
        wr(5'd25, 8'h01);
        @(negedge clk); pin_in[8] = 1'b1;
        idle(5);
        peek(5'd3, d); chk("R6 rising sets", d, 8'h01);
        wr(5'd3, 8'h00);
        peek(5'd3, d); chk("R4 write zero keeps bit", d, 8'h01);
        wr(5'd3, 8'h01);
        peek(5'd3, d); chk("R4 w1c", d, 8'h00);
        pin_in[8] = 1'b0;
        idle(5);
        peek(5'd3, d); chk("R6 falling sets", d, 8'h01);
        wr(5'd3, 8'h01);
        wr(5'd25, 8'h00);
    endtask

    task automatic t_coincide();
        logic [7:0] d;
        @(negedge clk); pin_in[16] = 1'b1;
        idle(5);
        pin_in[16] = 1'b0;
        idle(5);
        peek(5'd4, d); chk("R4 first event held", d, 8'h01);
        @(negedge clk); pin_in[16] = 1'b1;
        @(negedge clk);
        @(negedge clk); reg_wr = 1'b1; reg_addr = 5'd4; reg_wdata = 8'h01;
        @(negedge clk); reg_wr = 1'b0;
        peek(5'd4, d); chk("R10 edge wins over clear", d, 8'h01);
        wr(5'd4, 8'h01);
        peek(5'd4, d); chk("R10 later clear works", d, 8'h00);
    endtask

    task automatic t_route();
        wr(5'd10, 8'h01);
        @(negedge clk); pin_in[0] = 1'b1;
        idle(6);
        chk("R7 no route oe", {7'b0, smi_oe}, 8'h00);
        chk("R7 no route ser", {7'b0, serirq_slot2_req}, 8'h00);
        wr(5'd9, 8'h40); idle(1);
        chk("R7 ser routed", {7'b0, serirq_slot2_req}, 8'h01);
        chk("R7 pin not routed", {7'b0, smi_oe}, 8'h00);
        wr(5'd9, 8'h80); idle(1);
        chk("R7 pin routed", {7'b0, smi_oe}, 8'h01);
        chk("R7 ser not routed", {7'b0, serirq_slot2_req}, 8'h00);
    endtask

    task automatic t_outmode();
        wr(5'd31, 8'h01); idle(1);
        chk("R8 od active-high level", {6'b0, smi_oe, smi_o}, 8'h03);
        wr(5'd31, 8'h03); idle(1);
        chk("R8 pp active-high asserted", {6'b0, smi_oe, smi_o}, 8'h03);
        wr(5'd2, 8'h01); idle(2);
        chk("R8 pp active-high idle", {6'b0, smi_oe, smi_o}, 8'h02);
        wr(5'd31, 8'h02); idle(1);
        chk("R8 pp active-low idle", {6'b0, smi_oe, smi_o}, 8'h03);
        wr(5'd31, 8'h00); idle(1);
        chk("R8 od idle released", {6'b0, smi_oe, smi_o}, 8'h00);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_dev();
        t_ir();
        t_latency();
        t_pol();
        t_both();
        t_coincide();
        t_route();
        t_outmode();
        idle(2);
        finish_run();
    end
endmodule